// File: doc/BRIEF.md
# Clear-to-Send Change Monitor and Interrupt Combiner

This unit sits beside a serial channel's receiver and transmitter. It watches the incoming clear-to-send line through a synchronizer and a tick-driven persistence filter. A change in either direction that survives the filter is latched as a change-of-state event. The unit also collects the channel's interrupt sources into one status word: change of state, delta break, receiver, and transmitter. It gates that word with a software-written mask and ORs the result into a single interrupt request.

The unit also holds the request-to-send output. Software asserts the line (drives it low) through a set write and negates it (drives it high) through a clear write. The receiver and the transmitter can each request that the line be negated. Such a request forces it high until the next set write.

Top module: `cts_irq_unit`

## Requirements
- R1: After synchronous reset, `irq` is 0, `isr[3]` and `isr[2]` are 0, `ipc` is 2'b01 (no change, level high) and `rts` is 1.
- R2: A new level on `cts_pin` is accepted once it has been seen at the synchronizer output on FILT_TICKS consecutive cycles where `tick` is 1. Acceptance updates `ipc[0]` and sets the change flag `ipc[1]`, for both the falling and the rising direction.
- R3: A level that returns to the accepted value before FILT_TICKS ticks have counted sets no flag and leaves `ipc[0]` unchanged. Cycles with `tick` at 0 add nothing to the count.
- R4: `ipc` bit 1 is the change flag and bit 0 is the filtered CTS level.
- R5: A one-cycle `ipc_rd` clears the change flag. If a filtered change is accepted in the same cycle, the flag stays set.
- R6: `isr` bit 3 equals the change flag ANDed with `cos_en`.
- R7: `isr` bit 1 follows `rx_full` when `rx_src_full` is 1 and `rx_ready` when it is 0. `isr` bit 0 follows `tx_ready`.
- R8: `isr` bit 2 sets one cycle after a `break_det` pulse and clears after `cmd_rst_brk`. If both arrive in the same cycle, the set wins.
- R9: `mask_we` loads `mask_wdata` into a 4-bit mask that has the same bit layout as `isr`. `irq` is the OR of `isr` ANDed with that mask.
- R10: With `rts_set_we` and `out_wdata[0]`=1, `rts` goes to 0 on the next cycle. With `rts_clr_we` and `out_wdata[0]`=1, `rts` goes to 1 on the next cycle. Writes with `out_wdata[0]`=0 leave `rts` unchanged.
- R11: `rx_rts_neg` or `tx_rts_neg` drives `rts` to 1, and `rts` stays 1 until a set write. A set write in the same cycle as a negate request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_pin | input | 1 | Raw clear-to-send line |
| tick | input | 1 | Filter timebase strobe |
| cos_en | input | 1 | Enables the change flag into `isr` |
| rx_ready | input | 1 | Receiver has a character |
| rx_full | input | 1 | Receiver buffer is full |
| rx_src_full | input | 1 | 1 selects `rx_full` as the receiver source |
| tx_ready | input | 1 | Transmit holding register is empty |
| break_det | input | 1 | Break detected pulse |
| cmd_rst_brk | input | 1 | Reset-break-change command pulse |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 4 | Mask write data |
| ipc_rd | input | 1 | Input-change word read strobe |
| rts_set_we | input | 1 | Output set-register write |
| rts_clr_we | input | 1 | Output clear-register write |
| out_wdata | input | 1 | Output write data (RTS bit) |
| rx_rts_neg | input | 1 | Receiver request to negate RTS |
| tx_rts_neg | input | 1 | Transmitter request to negate RTS |
| irq | output | 1 | Masked interrupt request |
| isr | output | 4 | Status: {cos, delta break, rx, tx} |
| ipc | output | 2 | Input change: {change flag, CTS level} |
| rts | output | 1 | Request-to-send line level |

## Verification
The bench builds the unit with FILT_TICKS set to 3. Several boundaries then fall within a few cycles: a two-cycle glitch that must be rejected, a three-cycle low pulse that must be accepted, and the exact cycle where acceptance collides with a read. Holding `tick` low with a changed pin shows that the count depends on the strobe rather than on clock cycles.

// File: rtl/cts_irq_pkg.sv
package cts_irq_pkg;

    localparam int ISR_W = 4;

    typedef struct packed {
        logic cos;
        logic dbrk;
        logic rx;
        logic tx;
    } isr_t;

    typedef struct packed {
        logic flag;
        logic level;
    } ipc_t;

    function automatic logic rx_source(input logic sel_full, input logic rdy, input logic full);
        return sel_full ? full : rdy;
    endfunction

endpackage

// File: rtl/cts_filter.sv
module cts_filter #(
    parameter int FILT_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic tick,
    output logic level,
    output logic accept
);
    localparam int CNT_W = (FILT_TICKS > 1) ? $clog2(FILT_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_TICKS - 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic             differs;

    assign differs = (sync_q[1] != level);
    assign accept  = differs && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            level  <= 1'b1;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], pin};
            if (!differs) begin
                cnt_q <= '0;
            end else if (accept) begin
                level <= sync_q[1];
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import cts_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             ipc_rd,
    input  logic             cos_en,
    input  logic             rx_ready,
    input  logic             rx_full,
    input  logic             rx_src_full,
    input  logic             tx_ready,
    input  logic             break_det,
    input  logic             cmd_rst_brk,
    input  logic             mask_we,
    input  logic [ISR_W-1:0] mask_wdata,
    output logic             cos_flag,
    output isr_t             status,
    output logic [ISR_W-1:0] mask_q,
    output logic             irq
);
    logic dbrk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cos_flag <= 1'b0;
            dbrk_q   <= 1'b0;
            mask_q   <= '0;
        end else begin
            if (accept)      cos_flag <= 1'b1;
            else if (ipc_rd) cos_flag <= 1'b0;
            if (break_det)        dbrk_q <= 1'b1;
            else if (cmd_rst_brk) dbrk_q <= 1'b0;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    always_comb begin
        status.cos  = cos_flag & cos_en;
        status.dbrk = dbrk_q;
        status.rx   = rx_source(rx_src_full, rx_ready, rx_full);
        status.tx   = tx_ready;
        irq         = |(status & mask_q);
    end
endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic set_we,
    input  logic clr_we,
    input  logic wdata,
    input  logic rx_neg,
    input  logic tx_neg,
    output logic rts
);
    always_ff @(posedge clk) begin
        if (rst)                                   rts <= 1'b1;
        else if (set_we && wdata)                  rts <= 1'b0;
        else if ((clr_we && wdata) || rx_neg || tx_neg) rts <= 1'b1;
    end
endmodule

// File: rtl/cts_irq_unit.sv
module cts_irq_unit
    import cts_irq_pkg::*;
#(
    parameter int FILT_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cts_pin,
    input  logic       tick,
    input  logic       cos_en,
    input  logic       rx_ready,
    input  logic       rx_full,
    input  logic       rx_src_full,
    input  logic       tx_ready,
    input  logic       break_det,
    input  logic       cmd_rst_brk,
    input  logic       mask_we,
    input  logic [3:0] mask_wdata,
    input  logic       ipc_rd,
    input  logic       rts_set_we,
    input  logic       rts_clr_we,
    input  logic       out_wdata,
    input  logic       rx_rts_neg,
    input  logic       tx_rts_neg,
    output logic       irq,
    output logic [3:0] isr,
    output logic [1:0] ipc,
    output logic       rts
);
    logic             cts_level;
    logic             accept;
    logic             cos_flag;
    isr_t             status;
    logic [ISR_W-1:0] mask_q;
    ipc_t             ipc_w;

    cts_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
        .clk(clk), .rst(rst), .pin(cts_pin), .tick(tick),
        .level(cts_level), .accept(accept)
    );

    irq_combiner u_comb (
        .clk(clk), .rst(rst), .accept(accept), .ipc_rd(ipc_rd), .cos_en(cos_en),
        .rx_ready(rx_ready), .rx_full(rx_full), .rx_src_full(rx_src_full),
        .tx_ready(tx_ready), .break_det(break_det), .cmd_rst_brk(cmd_rst_brk),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .cos_flag(cos_flag), .status(status), .mask_q(mask_q), .irq(irq)
    );

    rts_ctrl u_rts (
        .clk(clk), .rst(rst), .set_we(rts_set_we), .clr_we(rts_clr_we),
        .wdata(out_wdata), .rx_neg(rx_rts_neg), .tx_neg(tx_rts_neg), .rts(rts)
    );

    always_comb begin
        ipc_w.flag  = cos_flag;
        ipc_w.level = cts_level;
        ipc         = ipc_w;
        isr         = status;
    end
endmodule

// File: rtl/cts_irq_unit_chk.sv
module cts_irq_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       accept,
    input logic       ipc_rd,
    input logic       break_det,
    input logic       cmd_rst_brk,
    input logic       rts_set_we,
    input logic       out_wdata,
    input logic       rx_rts_neg,
    input logic       tx_rts_neg,
    input logic [3:0] mask_q,
    input logic [3:0] isr,
    input logic [1:0] ipc,
    input logic       irq,
    input logic       rts
);
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (ipc_rd && !accept) |=> !ipc[1]);
    assert_accept_sets_R5: assert property (@(posedge clk) disable iff (rst)
        accept |=> ipc[1]);
    assert_break_sets_R8: assert property (@(posedge clk) disable iff (rst)
        break_det |=> isr[2]);
    assert_break_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_rst_brk && !break_det) |=> !isr[2]);
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
        irq == |(isr & mask_q));
    assert_set_low_R10: assert property (@(posedge clk) disable iff (rst)
        (rts_set_we && out_wdata) |=> !rts);
    assert_negate_high_R11: assert property (@(posedge clk) disable iff (rst)
        ((rx_rts_neg || tx_rts_neg) && !(rts_set_we && out_wdata)) |=> rts);
endmodule

bind cts_irq_unit cts_irq_unit_chk u_chk (
    .clk(clk), .rst(rst), .accept(accept), .ipc_rd(ipc_rd),
    .break_det(break_det), .cmd_rst_brk(cmd_rst_brk),
    .rts_set_we(rts_set_we), .out_wdata(out_wdata),
    .rx_rts_neg(rx_rts_neg), .tx_rts_neg(tx_rts_neg),
    .mask_q(mask_q), .isr(isr), .ipc(ipc), .irq(irq), .rts(rts)
);

// File: tb/cts_irq_unit_test.sv
module cts_irq_unit_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cts_pin = 1'b1, tick = 1'b1, cos_en = 1'b0;
    logic rx_ready = 1'b0, rx_full = 1'b0, rx_src_full = 1'b0, tx_ready = 1'b0;
    logic break_det = 1'b0, cmd_rst_brk = 1'b0, mask_we = 1'b0, ipc_rd = 1'b0;
    logic [3:0] mask_wdata = 4'h0;
    logic rts_set_we = 1'b0, rts_clr_we = 1'b0, out_wdata = 1'b0;
    logic rx_rts_neg = 1'b0, tx_rts_neg = 1'b0;
    logic irq, rts;
    logic [3:0] isr;
    logic [1:0] ipc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cts_irq_unit #(.FILT_TICKS(3)) uut (
        .clk(clk), .rst(rst), .cts_pin(cts_pin), .tick(tick), .cos_en(cos_en),
        .rx_ready(rx_ready), .rx_full(rx_full), .rx_src_full(rx_src_full),
        .tx_ready(tx_ready), .break_det(break_det), .cmd_rst_brk(cmd_rst_brk),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ipc_rd(ipc_rd),
        .rts_set_we(rts_set_we), .rts_clr_we(rts_clr_we), .out_wdata(out_wdata),
        .rx_rts_neg(rx_rts_neg), .tx_rts_neg(tx_rts_neg),
        .irq(irq), .isr(isr), .ipc(ipc), .rts(rts)
    );

    // {rx_ready, rx_full, tx_ready, rx_src_full, mask[3:0], exp_rx, exp_tx, exp_irq}
    localparam logic [10:0] VEC [8] = '{
        11'b1000_0010_101, 11'b1001_0010_000, 11'b0101_0010_101, 11'b0100_0010_000,
        11'b0010_0001_011, 11'b0010_0010_010, 11'b1111_0000_110, 11'b1010_1100_110
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        check(irq == 1'b0 && isr[3:2] == 2'b00, "R1", int'({irq, isr}), 0);
        check(ipc == 2'b01, "R1", int'(ipc), 1);
        check(rts == 1'b1, "R1", int'(rts), 1);

        // R7 / R9 vector walk
        foreach (VEC[k]) begin
            {rx_ready, rx_full, tx_ready, rx_src_full, mask_wdata} = VEC[k][10:3];
            mask_we = 1'b1;
            cyc(1);
            mask_we = 1'b0;
            check(isr[1:0] == VEC[k][2:1], "R7", int'(isr[1:0]), int'(VEC[k][2:1]));
            check(irq == VEC[k][0], "R9", int'(irq), int'(VEC[k][0]));
        end
        {rx_ready, rx_full, tx_ready, rx_src_full} = 4'b0000;

        // R3 two-cycle glitch rejected
        cts_pin = 1'b0; cyc(2); cts_pin = 1'b1; cyc(8);
        check(ipc == 2'b01, "R3", int'(ipc), 1);
        // R3 no ticks: no progress
        tick = 1'b0; cts_pin = 1'b0; cyc(10);
        check(ipc == 2'b01, "R3", int'(ipc), 1);
        // R2 falling change accepted once ticks run
        tick = 1'b1; cyc(8);
        check(ipc == 2'b10, "R2", int'(ipc), 2);
        // R6 flag gated by enable, R9 irq from cos
        mask_wdata = 4'b1000; mask_we = 1'b1; cyc(1); mask_we = 1'b0;
        check(isr[3] == 1'b0 && irq == 1'b0, "R6", int'(isr[3]), 0);
        cos_en = 1'b1; #1;
        check(isr[3] == 1'b1 && irq == 1'b1, "R6", int'({isr[3], irq}), 3);
        // R5 read clears
        ipc_rd = 1'b1; cyc(1); ipc_rd = 1'b0;
        check(ipc[1] == 1'b0, "R5", int'(ipc[1]), 0);
        check(irq == 1'b0, "R9", int'(irq), 0);
        // R2 rising change, R4 level in bit 0
        cts_pin = 1'b1; cyc(8);
        check(ipc == 2'b11, "R4", int'(ipc), 3);
        ipc_rd = 1'b1; cyc(1); ipc_rd = 1'b0;
        // R5 read colliding with acceptance: pin changes now, accept in the 5th cycle
        cts_pin = 1'b0; cyc(4);
        ipc_rd = 1'b1; cyc(1); ipc_rd = 1'b0;
        check(ipc == 2'b10, "R5", int'(ipc), 2);
        ipc_rd = 1'b1; cyc(1); ipc_rd = 1'b0;
        // R2 three-cycle pulse accepted (boundary)
        cts_pin = 1'b1; cyc(8);
        ipc_rd = 1'b1; cyc(1); ipc_rd = 1'b0;
        cts_pin = 1'b0; cyc(3); cts_pin = 1'b1; cyc(1);
        cyc(1);
        check(ipc[1] == 1'b1, "R2", int'(ipc[1]), 1);
        cyc(8);

        // R8 delta break
        break_det = 1'b1; cyc(1); break_det = 1'b0;
        check(isr[2] == 1'b1, "R8", int'(isr[2]), 1);
        break_det = 1'b1; cmd_rst_brk = 1'b1; cyc(1); break_det = 1'b0;
        check(isr[2] == 1'b1, "R8", int'(isr[2]), 1);
        cyc(1); cmd_rst_brk = 1'b0;
        check(isr[2] == 1'b0, "R8", int'(isr[2]), 0);

        // R10 set / clear writes
        rts_set_we = 1'b1; out_wdata = 1'b0; cyc(1);
        check(rts == 1'b1, "R10", int'(rts), 1);
        out_wdata = 1'b1; cyc(1); rts_set_we = 1'b0;
        check(rts == 1'b0, "R10", int'(rts), 0);
        rts_clr_we = 1'b1; out_wdata = 1'b0; cyc(1);
        check(rts == 1'b0, "R10", int'(rts), 0);
        out_wdata = 1'b1; cyc(1); rts_clr_we = 1'b0;
        check(rts == 1'b1, "R10", int'(rts), 1);

        // R11 negate requests
        rts_set_we = 1'b1; cyc(1); rts_set_we = 1'b0;
        tx_rts_neg = 1'b1; cyc(1); tx_rts_neg = 1'b0; cyc(2);
        check(rts == 1'b1, "R11", int'(rts), 1);
        rts_set_we = 1'b1; cyc(1); rts_set_we = 1'b0;
        rx_rts_neg = 1'b1; cyc(1);
        check(rts == 1'b1, "R11", int'(rts), 1);
        rts_set_we = 1'b1; cyc(1); rts_set_we = 1'b0; rx_rts_neg = 1'b0;
        check(rts == 1'b0, "R11", int'(rts), 0);

        // R1 reset again restores state
        mask_wdata = 4'hF; mask_we = 1'b1; break_det = 1'b1; cyc(1);
        mask_we = 1'b0; break_det = 1'b0;
        rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
        check(isr[2] == 1'b0 && irq == 1'b0 && rts == 1'b1, "R1", int'({isr[2], irq, rts}), 1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule